// File: doc/BRIEF.md
# FIFO Read-Side Replay Controller

This block is the read-side control of a single-clock FIFO, with a way to replay data that has already been read. It keeps the write and read positions of the FIFO memory and tells the memory which word the read side points at. It also drives the empty indication. When a retransmit request is accepted, the read position goes back to the first memory location and reading starts again from the start of memory. The memory array itself sits outside the block. The read and write sides share one clock.

A request is only accepted inside a defined window. Since the last master or partial reset, the FIFO must have taken in enough words and handed out enough words, and neither count may exceed a ceiling set by the depth and the timing mode. The enable inputs must also be quiet around the request. The normal-latency mode holds off reads for a short setup period after the rewind. In standard timing it also pulls the empty indication low during that period. The zero-latency mode rewinds without any pause. A request that breaks a rule changes nothing and raises a one-cycle error pulse. `DEPTH` must be a power of two.

Top module: `rtx_replay_ctrl`

## Requirements
- R1: While master reset (`mrstN`, asynchronous, active low) is asserted, and in the first cycle after it is released, `rdPtr` is 0, `emptyN` is 0 and `rtErr` is 0.
- R2: A write (`wrEnN` low) is taken when fewer than `DEPTH` words are held. A read (`rdEnN` low) is taken when at least one word is held and no setup is active, and it advances `rdPtr` by one modulo `DEPTH`. Outside setup, `emptyN` is 1 exactly when at least one word is held, and a read attempted while empty leaves `rdPtr` unchanged.
- R3: A request is `rtN` sampled low on a rising edge after it was sampled high on the edge before. An accepted request sets `rdPtr` to 0 at that edge, and the held word count becomes the number of words written since reset.
- R4: A request is accepted only if the words written and the words read since the last reset each lie in [2, D-2]. D is `DEPTH` when `fwftSel`=0 (standard timing) and `DEPTH`+1 when `fwftSel`=1 (first-word-fall-through timing).
- R5: In normal-latency mode (`zeroLatSel`=0), `wrEnN` and `rdEnN` must both be high on the request edge and on the edge before it. In either mode, `wrEnN` must be high on both of those edges.
- R6: In zero-latency mode (`zeroLatSel`=1), the level of `rdEnN` has no effect on acceptance. A read on the request edge is dropped, and reads are taken again from the next edge on.
- R7: In normal-latency mode, reads are blocked for `SETUP_LEN` (default 2) cycles after an accepted request. With standard timing, `emptyN` is held at 0 during those cycles, and the first replayed read is taken on the edge after `emptyN` returns to 1.
- R8: With first-word-fall-through timing in normal-latency mode, the setup period still blocks reads, but `emptyN` is not forced low and keeps following the held word count.
- R9: A request that fails R4 or R5 leaves `rdPtr` as the normal read rules make it, and `rtErr` is 1 for exactly the one cycle after the request edge.
- R10: A partial reset (`prstN` low on a rising edge, synchronous) clears both positions, both word counts, any setup in progress and `rtErr`.
- R11: Holding `rtN` low over several edges gives a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common read/write clock |
| mrstN | input | 1 | Master reset, asynchronous, active low |
| prstN | input | 1 | Partial reset, synchronous, active low |
| wrEnN | input | 1 | Write enable, active low |
| rdEnN | input | 1 | Read enable, active low |
| rtN | input | 1 | Retransmit request, active low |
| zeroLatSel | input | 1 | 1 selects zero-latency replay, 0 normal latency |
| fwftSel | input | 1 | 1 selects first-word-fall-through timing, 0 standard |
| rdPtr | output | $clog2(DEPTH) | Memory address of the next word to read |
| emptyN | output | 1 | 0 when empty or during a standard-timing setup |
| rtErr | output | 1 | One-cycle pulse for a rejected request |

## Verification
Some properties hold on every cycle, and these are checked continuously. An accepted rewind lands `rdPtr` on zero. The read position only holds, steps by one or returns to zero. The error pulse never lasts two cycles. A standard-timing setup shows as a low empty flag, and the read position stays frozen while the flag is low. Other behaviour depends on history, and only the bench scenarios can show it: the word-count window at both of its edges in each timing mode, the enable rules that differ between the latency modes, the exact cycle of the first replayed read, and a held request line giving one request.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  // Strobes from the control into the datapath, valid for the current cycle.
  typedef struct packed {
    logic rewind;      // accepted request: read position goes to start at this edge
    logic blockRead;   // setup in progress: no read is taken
    logic forceEmpty;  // standard-timing setup: empty flag held low
  } rtxStrobe_t;
endpackage

// File: rtl/rtx_datapath.sv
module rtx_datapath
  import rtx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  rtxStrobe_t       stb,
  output logic [PTR_W-1:0] rdPtr,
  output logic             emptyN,
  output logic [CNT_W-1:0] wrCnt,
  output logic [CNT_W-1:0] rdCnt
);
  localparam logic [PTR_W:0]   POS_ONE  = (PTR_W+1)'(1);
  localparam logic [PTR_W:0]   FULL_OCC = (PTR_W+1)'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH + 1);

  // Positions carry one extra wrap bit so that full and empty differ.
  logic [PTR_W:0] wrPos, rdPos, occ;
  logic           isEmpty, isFull, wrFire, rdFire;

  always_comb begin
    occ     = wrPos - rdPos;
    isEmpty = (occ == '0);
    isFull  = (occ == FULL_OCC);
    wrFire  = !wrEnN && !isFull;
    rdFire  = !rdEnN && !isEmpty && !stb.blockRead && !stb.rewind;
  end

  always_ff @(posedge clk or negedge mrstN) begin
    if (!mrstN) begin
      wrPos <= '0;
      rdPos <= '0;
      wrCnt <= '0;
      rdCnt <= '0;
    end else if (!prstN) begin
      wrPos <= '0;
      rdPos <= '0;
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      if (wrFire) wrPos <= wrPos + POS_ONE;
      if (stb.rewind)  rdPos <= '0;
      else if (rdFire) rdPos <= rdPos + POS_ONE;
      if (wrFire && wrCnt != CNT_MAX) wrCnt <= wrCnt + CNT_ONE;
      if (rdFire && rdCnt != CNT_MAX) rdCnt <= rdCnt + CNT_ONE;
    end
  end

  assign rdPtr  = rdPos[PTR_W-1:0];
  assign emptyN = !isEmpty && !stb.forceEmpty;
endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
  import rtx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 5,
  parameter int SETUP_LEN = 2
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             rtN,
  input  logic             zeroLatSel,
  input  logic             fwftSel,
  input  logic [CNT_W-1:0] wrCnt,
  input  logic [CNT_W-1:0] rdCnt,
  output rtxStrobe_t       stb,
  output logic             rtErr
);
  localparam int             SW         = $clog2(SETUP_LEN + 1);
  localparam logic [CNT_W-1:0] LO_LIMIT = CNT_W'(2);
  localparam logic [CNT_W-1:0] HI_STD   = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] HI_FWFT  = CNT_W'(DEPTH - 1);
  localparam logic [SW-1:0]  SETUP_INIT = SW'(SETUP_LEN);
  localparam logic [SW-1:0]  SETUP_ONE  = SW'(1);

  logic          rtPrevN, wrPrevN, rdPrevN;
  logic [SW-1:0] setupCnt;
  logic [CNT_W-1:0] hiLimit;
  logic          request, countOk, enableOk, accept, setupOn;

  always_comb begin
    hiLimit  = fwftSel ? HI_FWFT : HI_STD;
    request  = !rtN && rtPrevN;
    countOk  = (wrCnt >= LO_LIMIT) && (wrCnt <= hiLimit) &&
               (rdCnt >= LO_LIMIT) && (rdCnt <= hiLimit);
    enableOk = wrEnN && wrPrevN && (zeroLatSel || (rdEnN && rdPrevN));
    accept   = request && countOk && enableOk;
    setupOn  = (setupCnt != '0);
    stb.rewind     = accept;
    stb.blockRead  = setupOn;
    stb.forceEmpty = setupOn && !fwftSel;
  end

  always_ff @(posedge clk or negedge mrstN) begin
    if (!mrstN) begin
      rtPrevN  <= 1'b1;
      wrPrevN  <= 1'b1;
      rdPrevN  <= 1'b1;
      setupCnt <= '0;
      rtErr    <= 1'b0;
    end else if (!prstN) begin
      rtPrevN  <= 1'b1;
      wrPrevN  <= 1'b1;
      rdPrevN  <= 1'b1;
      setupCnt <= '0;
      rtErr    <= 1'b0;
    end else begin
      rtPrevN <= rtN;
      wrPrevN <= wrEnN;
      rdPrevN <= rdEnN;
      rtErr   <= request && !accept;
      if (accept && !zeroLatSel) setupCnt <= SETUP_INIT;
      else if (setupOn)          setupCnt <= setupCnt - SETUP_ONE;
    end
  end
endmodule

// File: rtl/rtx_replay_ctrl.sv
module rtx_replay_ctrl
  import rtx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int SETUP_LEN = 2,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             rtN,
  input  logic             zeroLatSel,
  input  logic             fwftSel,
  output logic [PTR_W-1:0] rdPtr,
  output logic             emptyN,
  output logic             rtErr
);
  rtxStrobe_t       ctrlStb;
  logic [CNT_W-1:0] wrCnt, rdCnt;

  rtx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SETUP_LEN(SETUP_LEN)) uCtrl (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .rtN(rtN), .zeroLatSel(zeroLatSel), .fwftSel(fwftSel),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .stb(ctrlStb), .rtErr(rtErr)
  );

  rtx_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .stb(ctrlStb), .rdPtr(rdPtr), .emptyN(emptyN), .wrCnt(wrCnt), .rdCnt(rdCnt)
  );
endmodule

// File: rtl/rtx_replay_ctrl_chk.sv
module rtx_replay_ctrl_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             mrstN,
  input logic             prstN,
  input logic             zeroLatSel,
  input logic             fwftSel,
  input logic             rewindStb,
  input logic [PTR_W-1:0] rdPtr,
  input logic             emptyN,
  input logic             rtErr
);
  assert_rewind_start_R3: assert property (@(posedge clk) disable iff (!mrstN)
    (rewindStb && prstN) |=> (rdPtr == '0));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!mrstN)
    prstN |=> (rdPtr == $past(rdPtr) || rdPtr == $past(rdPtr) + 1'b1 || rdPtr == '0));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!mrstN)
    rtErr |=> !rtErr);

  assert_setup_empty_R7: assert property (@(posedge clk) disable iff (!mrstN)
    (rewindStb && prstN && !zeroLatSel && !fwftSel) |=> !emptyN);

  assert_frozen_when_empty_R7: assert property (@(posedge clk) disable iff (!mrstN)
    (!emptyN && !rewindStb && prstN) |=> $stable(rdPtr));
endmodule

bind rtx_replay_ctrl rtx_replay_ctrl_chk #(.PTR_W(PTR_W)) uChk (
  .clk(clk), .mrstN(mrstN), .prstN(prstN), .zeroLatSel(zeroLatSel),
  .fwftSel(fwftSel), .rewindStb(ctrlStb.rewind), .rdPtr(rdPtr),
  .emptyN(emptyN), .rtErr(rtErr)
);

// File: tb/sim_rtx_replay_ctrl.sv
module sim_rtx_replay_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic clk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1, wrEnN = 1'b1, rdEnN = 1'b1, rtN = 1'b1;
  logic zeroLatSel = 1'b0, fwftSel = 1'b0;
  logic [3:0] rdPtr;
  logic emptyN, rtErr;
  logic curZl = 1'b0, curFw = 1'b0;
  int   testCount = 0, failCount = 0;
  bit   done = 1'b0;

  typedef struct {
    logic [3:0] ptr;
    logic       emp;
    logic       err;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtx_replay_ctrl #(.DEPTH(DEPTH), .SETUP_LEN(2)) u0 (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .rtN(rtN), .zeroLatSel(zeroLatSel), .fwftSel(fwftSel),
    .rdPtr(rdPtr), .emptyN(emptyN), .rtErr(rtErr)
  );

  // Monitor: compares the outputs settled after each edge against the queue.
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      exp_t e;
      e = expQ.pop_front();
      testCount++;
      if (rdPtr !== e.ptr || emptyN !== e.emp || rtErr !== e.err) begin
        failCount++;
        $display("FAIL %s: rdPtr=%0d emptyN=%0b rtErr=%0b expected rdPtr=%0d emptyN=%0b rtErr=%0b",
                 e.tag, rdPtr, emptyN, rtErr, e.ptr, e.emp, e.err);
      end
    end
  end

  // Driver: one cycle of stimulus, expected outputs after its edge.
  task automatic step(input logic p, input logic w, input logic r, input logic t,
                      input logic [3:0] ePtr, input logic eEmp, input logic eErr,
                      input string tag);
    exp_t e;
    @(negedge clk);
    prstN = p; wrEnN = w; rdEnN = r; rtN = t;
    zeroLatSel = curZl; fwftSel = curFw;
    @(posedge clk);
    e.ptr = ePtr; e.emp = eEmp; e.err = eErr; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    mrstN = 1'b1;
    step(1,1,1,1, 0,0,0, "R1 reset state");

    // Standard timing, normal latency.
    for (int i = 0; i < 4; i++) step(1,0,1,1, 0,1,0, "R2 write fills");
    step(1,1,0,1, 1,1,0, "R2 read 1");
    step(1,1,0,1, 2,1,0, "R2 read 2");
    step(1,1,0,1, 3,1,0, "R2 read 3");
    step(1,1,1,1, 3,1,0, "R2 idle");
    step(1,1,1,0, 0,0,0, "R3 rewind to start, R7 empty low");
    step(1,1,0,0, 0,0,0, "R7 read blocked, R11 held request");
    step(1,1,0,0, 0,1,0, "R7 empty released, read still blocked");
    step(1,1,0,1, 1,1,0, "R7 first replayed read");
    step(1,1,0,1, 2,1,0, "R2 replay read");
    step(1,1,0,1, 3,1,0, "R2 replay read");
    step(1,1,0,1, 4,0,0, "R2 replay drains");
    step(1,1,0,1, 4,0,0, "R2 read while empty ignored");

    // Enable rule, normal latency.
    step(1,0,1,1, 4,1,0, "R2 write");
    step(1,0,1,1, 4,1,0, "R2 write");
    step(1,1,0,0, 5,1,1, "R5 read active at request, R9 error");
    step(1,1,1,1, 5,1,0, "R9 error lasts one cycle");

    // Word window, lower edge.
    step(0,1,1,1, 0,0,0, "R10 partial reset clears");
    step(1,0,1,1, 0,1,0, "R2 write");
    step(1,1,0,1, 1,0,0, "R2 read");
    step(1,1,1,1, 1,0,0, "R2 idle");
    step(1,1,1,0, 1,0,1, "R4 too few words rejected");
    step(1,1,1,1, 1,0,0, "R9 idle");

    // Word window, upper edge in both timing modes.
    step(0,1,1,1, 0,0,0, "R10 partial reset clears");
    for (int i = 0; i < 15; i++) step(1,0,1,1, 0,1,0, "R2 write 15");
    step(1,1,0,1, 1,1,0, "R2 read");
    step(1,1,0,1, 2,1,0, "R2 read");
    step(1,1,1,1, 2,1,0, "R2 idle");
    step(1,1,1,0, 2,1,1, "R4 15 written exceeds D-2 in standard timing");
    curFw = 1'b1;
    step(1,1,1,1, 2,1,0, "R4 idle");
    step(1,1,1,0, 0,1,0, "R4 15 written legal in fwft, R8 empty not forced");
    step(1,1,0,0, 0,1,0, "R8 read blocked");
    step(1,1,0,0, 0,1,0, "R8 read blocked");
    step(1,1,0,1, 1,1,0, "R8 first replayed read");

    // Zero latency, standard timing.
    curZl = 1'b1; curFw = 1'b0;
    step(0,1,1,1, 0,0,0, "R10 partial reset clears");
    for (int i = 0; i < 4; i++) step(1,0,1,1, 0,1,0, "R2 write");
    step(1,1,0,1, 1,1,0, "R2 read");
    step(1,1,0,1, 2,1,0, "R2 read");
    step(1,1,0,0, 0,1,0, "R6 rewind with read active, read dropped");
    step(1,1,0,1, 1,1,0, "R6 read taken on next edge");
    step(1,0,1,0, 1,1,1, "R5 write active at request rejected");
    step(1,1,1,1, 1,1,0, "R9 idle");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule